// File: doc/BRIEF.md
# Round-Robin Store Buffer with Purge-Time Integrity Checks

This block holds up to eight pending stores for one hardware thread. Each slot keeps a 64-bit store word with check bits, a physical address with an 8-bit byte-mask field (the compare field), a 2-bit privilege code and one parity bit over the compare field. Slots are handed out in strict rotation by a wrapping write pointer. When a slot is about to be reused, or when a periodic flush reaches it, its contents are purged. The purge shows the entry on a drain port and checks the entry's integrity.

The integrity check runs one cycle after the purge is requested. It classifies the entry as clean, single-bit (correctable), multi-bit (uncorrectable) or compare-field parity failure. It records the first reported error in a status register. A store whose purge reports an error is refused. Entries written through the alternate address space are stored like any other but are never checked or drained. Error injection inputs let a test corrupt the check bits or the parity bit as a store is written.

Top module: `rr_store_buffer`

## Requirements
- R1: Accepted stores fill slots 0,1,...,7 in order and the pointer then wraps to 0. A refused store leaves the pointer where it was.
- R2: A store request is taken when `st_ready` is 1. Two cycles later `st_done` pulses for one cycle. If the slot at the pointer held a valid, non-alternate entry, `drain_valid` pulses in the same cycle with that slot's index, address, mask and stored word.
- R3: Each 32-bit half of the word has 7 check bits. Flipping exactly one stored check bit of a half reports a correctable error (`stat_kind` 1). Flipping two reports an uncorrectable error (`stat_kind` 2). `stat_idx` holds the purged slot.
- R4: `en_ue` gates uncorrectable reports and `en_ce` gates correctable reports. When an entry's error is gated off, nothing is recorded and the store is accepted. The drain still happens.
- R5: A compare-field parity mismatch reports `stat_kind` 3 and is never gated. `stat_priv` then holds the highest privilege code among all valid slots (0 user, 1 supervisor, 2 hypervisor). If any valid slot holds code 3, `stat_priv` is 3 (unknown). For other error kinds `stat_priv` is 0.
- R6: When one purge finds several errors, parity outranks uncorrectable, which outranks correctable.
- R7: A purge that reports an error refuses the store. `st_ok` is 0 and the slot is left invalid.
- R8: A purged slot is always invalidated, so retrying into it neither drains nor reports again.
- R9: Alternate-space entries skip every check. Overwriting or flushing one gives no drain and no error, even when they were written with injected faults.
- R10: Each `flush_tick` seen while idle and with no store request is counted. When the count reaches `flush_rate` (0 acts as 1), the count restarts. The pointer then advances by one and the slot at the new pointer is purged.
- R11: An error reported while `stat_valid` is 1 sets `stat_multi` and keeps the first error. `err_clr` empties the status.
- R12: After reset `st_ready` is 1, all slots are empty and every status and pulse output is 0.
- R13: A `flush_tick` in the same cycle as a store request is dropped and is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Block idle, request will be taken |
| st_is_alt | input | 1 | Store targets the alternate address space |
| st_addr | input | ADDR_W | Physical address |
| st_mask | input | MASK_W | Byte mask or alternate-space number |
| st_data | input | 64 | Store word |
| st_ctl | input | 2 | Privilege code |
| inj_data_en | input | 1 | Apply `inj_mask` to both halves' check bits |
| inj_mask | input | 7 | Check-bit flip mask |
| inj_par_en | input | 1 | Store inverted compare-field parity |
| en_ue | input | 1 | Enable uncorrectable reports |
| en_ce | input | 1 | Enable correctable reports |
| flush_tick | input | 1 | Periodic flush event |
| flush_rate | input | RATE_W | Ticks per flush |
| err_clr | input | 1 | Clear error status |
| st_done | output | 1 | Store outcome pulse |
| st_ok | output | 1 | Store was written (valid with `st_done`) |
| drain_valid | output | 1 | Purged entry shown |
| drain_idx | output | 3 | Purged slot |
| drain_addr | output | ADDR_W | Purged address |
| drain_mask | output | MASK_W | Purged mask |
| drain_data | output | 64 | Purged word, uncorrected |
| stat_valid | output | 1 | Status holds an error |
| stat_kind | output | 2 | 1 correctable, 2 uncorrectable, 3 parity |
| stat_idx | output | 3 | Slot of recorded error |
| stat_priv | output | 2 | Privilege summary for parity errors |
| stat_multi | output | 1 | Further error while status full |

## Verification
Directed sequences first fill all eight slots and then wrap, so that plain reuse, reuse of an alternate-space slot and reuse of slots with one or two flipped check bits or a flipped parity bit are seen apart. Paired runs with the report enables on and off separate gating from detection. Slots with mixed privilege codes, including the corrupt code, separate the privilege summary from the plain slot index. A seeded random phase then mixes stores, faults, flush ticks at several rates, clears and enable changes. A reference model tracks pointer, occupancy and status, so wrap order, refusal and multiple-error retention are compared on every operation.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int WORD_W = 64;
  localparam int HALF_W = 32;
  localparam int CHK_W  = 7;
  localparam int CODE_N = HALF_W + CHK_W - 1;  // positions 1..38

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_CE   = 2'd1,
    ERR_UE   = 2'd2,
    ERR_PAR  = 2'd3
  } err_kind_e;

  // Hamming positions: check bits at powers of two, data elsewhere,
  // top check bit is overall parity over data and lower check bits.
  function automatic logic [CHK_W-1:0] ecc_gen(input logic [HALF_W-1:0] d);
    logic [CHK_W-1:0] c;
    int k;
    c = '0;
    k = 0;
    for (int p = 1; p <= CODE_N; p++) begin
      if ((p & (p - 1)) != 0) begin
        for (int i = 0; i < CHK_W - 1; i++)
          if (((p >> i) & 1) != 0) c[i] = c[i] ^ d[k];
        k++;
      end
    end
    c[CHK_W-1] = (^d) ^ (^c[CHK_W-2:0]);
    return c;
  endfunction

  // 0 clean, 1 single-bit, 2 multi-bit
  function automatic logic [1:0] ecc_class(input logic [HALF_W-1:0] d,
                                           input logic [CHK_W-1:0] c);
    logic [CHK_W-1:0] r;
    logic [CHK_W-2:0] syn;
    logic ovr;
    r   = ecc_gen(d);
    syn = r[CHK_W-2:0] ^ c[CHK_W-2:0];
    ovr = (^d) ^ (^c);
    if (ovr) return 2'd1;
    if (syn != '0) return 2'd2;
    return 2'd0;
  endfunction
endpackage

// File: rtl/sb_word_check.sv
module sb_word_check
  import sb_pkg::*;
(
  input  logic [WORD_W-1:0]  data,
  input  logic [2*CHK_W-1:0] chk,
  output logic               ce,
  output logic               ue
);
  localparam int HALVES = WORD_W / HALF_W;
  logic [HALVES-1:0] ce_h, ue_h;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    logic [1:0] cls;
    assign cls     = ecc_class(data[h*HALF_W +: HALF_W], chk[h*CHK_W +: CHK_W]);
    assign ce_h[h] = (cls == 2'd1);
    assign ue_h[h] = (cls == 2'd2);
  end

  assign ue = |ue_h;
  assign ce = |ce_h;
endmodule

// File: rtl/sb_priv_scan.sv
module sb_priv_scan #(
  parameter int ENTRIES = 8
) (
  input  logic [ENTRIES-1:0]   vld,
  input  logic [2*ENTRIES-1:0] ctl_flat,
  output logic [1:0]           top_priv
);
  always_comb begin
    logic [1:0] best;
    logic bad;
    best = 2'd0;
    bad  = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (vld[i]) begin
        if (ctl_flat[2*i +: 2] == 2'd3) bad = 1'b1;
        else if (ctl_flat[2*i +: 2] > best) best = ctl_flat[2*i +: 2];
      end
    end
    top_priv = bad ? 2'd3 : best;
  end
endmodule

// File: rtl/sb_flush_timer.sv
module sb_flush_timer #(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [RATE_W-1:0] rate,
  output logic              fire
);
  logic [RATE_W-1:0] cnt_q;
  logic [RATE_W:0]   nxt;

  assign nxt  = {1'b0, cnt_q} + 1'b1;
  assign fire = tick && (nxt >= {1'b0, rate});

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (tick) cnt_q <= fire ? '0 : nxt[RATE_W-1:0];
  end

  assert_cnt_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> cnt_q == '0);
endmodule

// File: rtl/rr_store_buffer.sv
module rr_store_buffer
  import sb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 40,
  parameter int MASK_W  = 8,
  parameter int RATE_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     st_valid,
  output logic                     st_ready,
  input  logic                     st_is_alt,
  input  logic [ADDR_W-1:0]        st_addr,
  input  logic [MASK_W-1:0]        st_mask,
  input  logic [63:0]              st_data,
  input  logic [1:0]               st_ctl,
  input  logic                     inj_data_en,
  input  logic [6:0]               inj_mask,
  input  logic                     inj_par_en,
  input  logic                     en_ue,
  input  logic                     en_ce,
  input  logic                     flush_tick,
  input  logic [RATE_W-1:0]        flush_rate,
  input  logic                     err_clr,
  output logic                     st_done,
  output logic                     st_ok,
  output logic                     drain_valid,
  output logic [$clog2(ENTRIES)-1:0] drain_idx,
  output logic [ADDR_W-1:0]        drain_addr,
  output logic [MASK_W-1:0]        drain_mask,
  output logic [63:0]              drain_data,
  output logic                     stat_valid,
  output logic [1:0]               stat_kind,
  output logic [$clog2(ENTRIES)-1:0] stat_idx,
  output logic [1:0]               stat_priv,
  output logic                     stat_multi
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int ECC_W = 2 * CHK_W;

  // slot storage
  logic [ENTRIES-1:0] vld_q, alt_q;
  logic [ADDR_W-1:0]  addr_q [ENTRIES];
  logic [MASK_W-1:0]  mask_q [ENTRIES];
  logic [WORD_W-1:0]  data_q [ENTRIES];
  logic [ECC_W-1:0]   ecc_q  [ENTRIES];
  logic [ENTRIES-1:0] par_q;
  logic [2*ENTRIES-1:0] ctl_q;

  logic [IDX_W-1:0] wr_ptr;
  logic             pend_q, pend_st_q, chk_go_q;
  logic [IDX_W-1:0] chk_idx_q;

  // staged store
  logic              ps_alt, ps_par;
  logic [ADDR_W-1:0] ps_addr;
  logic [MASK_W-1:0] ps_mask;
  logic [WORD_W-1:0] ps_data;
  logic [ECC_W-1:0]  ps_ecc;
  logic [1:0]        ps_ctl;

  // named internal events
  logic             store_take, tick_ok, flush_fire, purge_fire;
  logic             store_commit, err_hit, par_err, w_ce, w_ue;
  logic [1:0]       kind_now, scan_priv;
  logic [IDX_W-1:0] flush_slot;
  logic [CHK_W-1:0] inj_eff;
  logic [ECC_W-1:0] new_ecc;
  logic             new_par;

  assign store_take = st_valid && !pend_q;
  assign tick_ok    = flush_tick && !pend_q && !st_valid;
  assign flush_slot = wr_ptr + 1'b1;
  assign st_ready   = !pend_q;

  assign inj_eff = inj_data_en ? inj_mask : '0;
  assign new_ecc = {ecc_gen(st_data[63:32]) ^ inj_eff,
                    ecc_gen(st_data[31:0])  ^ inj_eff};
  assign new_par = (^{st_addr, st_mask}) ^ inj_par_en;

  sb_flush_timer #(.RATE_W(RATE_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick_ok), .rate(flush_rate),
    .fire(flush_fire));

  sb_word_check u_wchk (
    .data(data_q[chk_idx_q]), .chk(ecc_q[chk_idx_q]), .ce(w_ce), .ue(w_ue));

  sb_priv_scan #(.ENTRIES(ENTRIES)) u_scan (
    .vld(vld_q), .ctl_flat(ctl_q), .top_priv(scan_priv));

  assign par_err    = ^{addr_q[chk_idx_q], mask_q[chk_idx_q], par_q[chk_idx_q]};
  assign purge_fire = pend_q && chk_go_q;

  always_comb begin
    kind_now = ERR_NONE;
    if (purge_fire) begin
      if (par_err)            kind_now = ERR_PAR;
      else if (w_ue)          kind_now = en_ue ? ERR_UE : ERR_NONE;
      else if (w_ce && en_ce) kind_now = ERR_CE;
    end
  end

  assign err_hit      = (kind_now != ERR_NONE);
  assign store_commit = pend_q && pend_st_q && !err_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0; alt_q <= '0; par_q <= '0; ctl_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        addr_q[i] <= '0; mask_q[i] <= '0; data_q[i] <= '0; ecc_q[i] <= '0;
      end
      wr_ptr <= '0; pend_q <= 1'b0; pend_st_q <= 1'b0; chk_go_q <= 1'b0;
      chk_idx_q <= '0;
      ps_alt <= 1'b0; ps_par <= 1'b0; ps_addr <= '0; ps_mask <= '0;
      ps_data <= '0; ps_ecc <= '0; ps_ctl <= '0;
      st_done <= 1'b0; st_ok <= 1'b0; drain_valid <= 1'b0; drain_idx <= '0;
      drain_addr <= '0; drain_mask <= '0; drain_data <= '0;
    end else begin
      st_done     <= 1'b0;
      drain_valid <= 1'b0;
      if (store_take) begin
        pend_q <= 1'b1; pend_st_q <= 1'b1;
        chk_go_q  <= vld_q[wr_ptr] && !alt_q[wr_ptr];
        chk_idx_q <= wr_ptr;
        ps_alt <= st_is_alt; ps_addr <= st_addr; ps_mask <= st_mask;
        ps_data <= st_data; ps_ecc <= new_ecc; ps_par <= new_par;
        ps_ctl <= st_ctl;
      end else if (flush_fire) begin
        pend_q <= 1'b1; pend_st_q <= 1'b0;
        chk_go_q  <= vld_q[flush_slot] && !alt_q[flush_slot];
        chk_idx_q <= flush_slot;
        wr_ptr    <= flush_slot;
      end
      if (pend_q) begin
        pend_q <= 1'b0;
        if (chk_go_q) begin
          vld_q[chk_idx_q] <= 1'b0;
          drain_valid <= 1'b1;
          drain_idx   <= chk_idx_q;
          drain_addr  <= addr_q[chk_idx_q];
          drain_mask  <= mask_q[chk_idx_q];
          drain_data  <= data_q[chk_idx_q];
        end
        if (pend_st_q) begin
          st_done <= 1'b1;
          st_ok   <= !err_hit;
        end
        if (store_commit) begin
          vld_q[chk_idx_q]  <= 1'b1;
          alt_q[chk_idx_q]  <= ps_alt;
          addr_q[chk_idx_q] <= ps_addr;
          mask_q[chk_idx_q] <= ps_mask;
          data_q[chk_idx_q] <= ps_data;
          ecc_q[chk_idx_q]  <= ps_ecc;
          par_q[chk_idx_q]  <= ps_par;
          ctl_q[2*chk_idx_q +: 2] <= ps_ctl;
          wr_ptr <= chk_idx_q + 1'b1;
        end
      end
    end
  end

  // error status register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_valid <= 1'b0; stat_kind <= '0; stat_idx <= '0;
      stat_priv <= '0; stat_multi <= 1'b0;
    end else if (err_hit) begin
      if (stat_valid && !err_clr) stat_multi <= 1'b1;
      else begin
        stat_valid <= 1'b1; stat_kind <= kind_now; stat_idx <= chk_idx_q;
        stat_priv  <= (kind_now == ERR_PAR) ? scan_priv : 2'd0;
        stat_multi <= 1'b0;
      end
    end else if (err_clr) begin
      stat_valid <= 1'b0; stat_kind <= '0; stat_idx <= '0;
      stat_priv <= '0; stat_multi <= 1'b0;
    end
  end

  assert_ptr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    store_commit |=> wr_ptr == IDX_W'($past(chk_idx_q) + 1'b1));

  assert_check_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> !pend_q);

  assert_refusal_logged_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_done && !st_ok) |-> stat_valid);

  assert_purged_gone_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (purge_fire && err_hit) |=> !vld_q[$past(chk_idx_q)]);

  assert_alt_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && alt_q[chk_idx_q]) |=> !drain_valid && $stable(stat_kind));

  assert_multi_needs_entry_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stat_multi |-> stat_valid);
endmodule

// File: tb/test_rr_store_buffer.sv
`timescale 1ns/1ps
module test_rr_store_buffer;
  localparam int N = 8;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, st_valid, st_ready, st_is_alt;
  logic [39:0] st_addr;
  logic [7:0]  st_mask;
  logic [63:0] st_data;
  logic [1:0]  st_ctl;
  logic inj_data_en, inj_par_en, en_ue, en_ce, flush_tick, err_clr;
  logic [6:0]  inj_mask;
  logic [15:0] flush_rate;
  logic st_done, st_ok, drain_valid, stat_valid, stat_multi;
  logic [2:0]  drain_idx, stat_idx;
  logic [39:0] drain_addr;
  logic [7:0]  drain_mask;
  logic [63:0] drain_data;
  logic [1:0]  stat_kind, stat_priv;

  rr_store_buffer i_rr_store_buffer (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_is_alt(st_is_alt), .st_addr(st_addr), .st_mask(st_mask),
    .st_data(st_data), .st_ctl(st_ctl), .inj_data_en(inj_data_en),
    .inj_mask(inj_mask), .inj_par_en(inj_par_en), .en_ue(en_ue),
    .en_ce(en_ce), .flush_tick(flush_tick), .flush_rate(flush_rate),
    .err_clr(err_clr), .st_done(st_done), .st_ok(st_ok),
    .drain_valid(drain_valid), .drain_idx(drain_idx),
    .drain_addr(drain_addr), .drain_mask(drain_mask),
    .drain_data(drain_data), .stat_valid(stat_valid),
    .stat_kind(stat_kind), .stat_idx(stat_idx), .stat_priv(stat_priv),
    .stat_multi(stat_multi));

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model
  bit          m_vld[N], m_alt[N], m_par[N];
  logic [39:0] m_addr[N];
  logic [7:0]  m_mask[N];
  logic [63:0] m_data[N];
  logic [1:0]  m_ctl[N];
  int          m_ecc[N];
  int          m_ptr, m_cnt;
  bit          s_vld, s_multi;
  logic [1:0]  s_kind, s_priv;
  logic [2:0]  s_idx;
  bit          e_drain;
  int          e_didx;

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [1:0] model_priv();
    bit bad = 0, hyp = 0, sup = 0;
    for (int i = 0; i < N; i++) if (m_vld[i]) begin
      if (m_ctl[i] == 2'd3) bad = 1;
      else if (m_ctl[i] == 2'd2) hyp = 1;
      else if (m_ctl[i] == 2'd1) sup = 1;
    end
    return bad ? 2'd3 : hyp ? 2'd2 : sup ? 2'd1 : 2'd0;
  endfunction

  // returns reported kind (0 none)
  function automatic int model_purge(input int idx);
    int k = 0;
    e_drain = 0;
    if (m_vld[idx] && !m_alt[idx]) begin
      e_drain = 1; e_didx = idx;
      if (m_par[idx]) k = 3;
      else if (m_ecc[idx] == 2) k = en_ue ? 2 : 0;
      else if (m_ecc[idx] == 1 && en_ce) k = 1;
      if (k != 0) begin
        if (s_vld) s_multi = 1;
        else begin
          s_vld = 1; s_kind = 2'(k); s_idx = 3'(idx); s_multi = 0;
          s_priv = (k == 3) ? model_priv() : 2'd0;
        end
      end
      m_vld[idx] = 0;
    end
    return k;
  endfunction

  task automatic compare(input string tag, input bit was_store, input bit exp_ok);
    chk(tag, "st_done", st_done, was_store);
    if (was_store) chk(tag, "st_ok", st_ok, exp_ok);
    chk(tag, "drain_valid", drain_valid, e_drain);
    if (e_drain) begin
      chk(tag, "drain_idx", drain_idx, e_didx);
      chk(tag, "drain_addr", drain_addr, m_addr[e_didx]);
      chk(tag, "drain_mask", drain_mask, m_mask[e_didx]);
      chk(tag, "drain_data", drain_data, m_data[e_didx]);
    end
    chk(tag, "stat_valid", stat_valid, s_vld);
    if (s_vld) begin
      chk(tag, "stat_kind", stat_kind, s_kind);
      chk(tag, "stat_idx", stat_idx, s_idx);
      chk(tag, "stat_priv", stat_priv, s_priv);
      chk(tag, "stat_multi", stat_multi, s_multi);
    end
    chk(tag, "st_ready", st_ready, 1'b1);
  endtask

  task automatic do_store(input string tag, input bit alt, input logic [39:0] a,
                          input logic [7:0] m, input logic [63:0] d,
                          input logic [1:0] c, input bit injd,
                          input logic [6:0] injm, input bit injp, input bit tk);
    int slot = m_ptr;
    int k;
    bit ok;
    // drain fields shown are the old contents: capture before overwrite
    k  = model_purge(slot);
    ok = (k == 0);
    @(negedge clk);
    st_valid = 1; st_is_alt = alt; st_addr = a; st_mask = m; st_data = d;
    st_ctl = c; inj_data_en = injd; inj_mask = injm; inj_par_en = injp;
    flush_tick = tk;
    @(negedge clk);
    st_valid = 0; inj_data_en = 0; inj_par_en = 0; flush_tick = 0;
    @(posedge clk);
    #1;
    compare(tag, 1, ok);
    if (ok) begin
      m_vld[slot] = 1; m_alt[slot] = alt; m_addr[slot] = a; m_mask[slot] = m;
      m_data[slot] = d; m_ctl[slot] = c; m_par[slot] = injp;
      m_ecc[slot] = injd ? $countones(injm) : 0;
      m_ptr = (slot + 1) % N;
    end
  endtask

  task automatic do_tick(input string tag);
    int k;
    int r = (flush_rate == 0) ? 1 : int'(flush_rate);
    e_drain = 0;
    if (m_cnt + 1 >= r) begin
      m_cnt = 0; m_ptr = (m_ptr + 1) % N;
      k = model_purge(m_ptr);
    end else m_cnt++;
    @(negedge clk); flush_tick = 1;
    @(negedge clk); flush_tick = 0;
    @(posedge clk); #1;
    compare(tag, 0, 1'b1);
  endtask

  task automatic do_clr(input string tag);
    s_vld = 0; s_multi = 0; e_drain = 0;
    @(negedge clk); err_clr = 1;
    @(negedge clk); err_clr = 0;
    @(posedge clk); #1;
    compare(tag, 0, 1'b1);
  endtask

  task automatic fill(input string tag, input int n, input logic [1:0] c);
    for (int i = 0; i < n; i++)
      do_store(tag, 0, 40'(64'h100 * (i + 1) + m_ptr), 8'hff, {$urandom, $urandom},
               c, 0, 7'd0, 0, 0);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed_sink;
    seed_sink = $urandom(32'h5eed_0042);
    rst_n = 0; st_valid = 0; st_is_alt = 0; st_addr = '0; st_mask = '0;
    st_data = '0; st_ctl = '0; inj_data_en = 0; inj_mask = '0; inj_par_en = 0;
    en_ue = 1; en_ce = 1; flush_tick = 0; flush_rate = 16'd1000; err_clr = 0;
    for (int i = 0; i < N; i++) begin
      m_vld[i] = 0; m_alt[i] = 0; m_par[i] = 0; m_ecc[i] = 0; m_ctl[i] = 0;
      m_addr[i] = '0; m_mask[i] = '0; m_data[i] = '0;
    end
    m_ptr = 0; m_cnt = 0; s_vld = 0; s_multi = 0; s_kind = 0; s_priv = 0;
    s_idx = 0; e_drain = 0; e_didx = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R12", "st_ready", st_ready, 1);
    chk("R12", "stat_valid", stat_valid, 0);
    chk("R12", "st_done", st_done, 0);
    chk("R12", "drain_valid", drain_valid, 0);
    @(negedge clk); rst_n = 1;

    // R1: fill eight slots; slot 3 alternate with injected faults (R9)
    fill("R1", 3, 2'd0);
    do_store("R9", 1, 40'h3333, 8'h42, 64'h0123_4567_89ab_cdef, 2'd1,
             1, 7'b0000011, 1, 0);
    fill("R1", 4, 2'd1);
    // R2: wrap and purge slot 0
    do_store("R2", 0, 40'hA000, 8'h0f, 64'hdead_beef_0000_0001, 2'd0, 0, 0, 0, 0);
    // R3 single-bit at slot 1
    do_store("R3", 0, 40'hA100, 8'h03, 64'h1111_2222_3333_4444, 2'd2, 1, 7'b0000100, 0, 0);
    fill("R9", 7, 2'd0);            // overwrites alternate slot 3 silently
    do_store("R3", 0, 40'hA200, 8'h01, 64'h5, 2'd0, 0, 0, 0, 0);  // CE, refused R7
    do_store("R8", 0, 40'hA200, 8'h01, 64'h5, 2'd0, 0, 0, 0, 0);  // retry, no report
    do_clr("R11");
    // R3 two-bit
    do_store("R3", 0, 40'hB000, 8'h80, 64'hffff_0000_ffff_0000, 2'd1, 1, 7'b1000001, 0, 0);
    fill("R3", 7, 2'd1);
    do_store("R3", 0, 40'hB100, 8'h11, 64'h77, 2'd0, 0, 0, 0, 0);
    do_store("R7", 0, 40'hB100, 8'h11, 64'h77, 2'd0, 0, 0, 0, 0);
    do_clr("R11");
    // R4 gating off
    en_ue = 0; en_ce = 0;
    do_store("R4", 0, 40'hC000, 8'h22, 64'h9, 2'd0, 1, 7'b0110000, 0, 0);
    do_store("R4", 0, 40'hC100, 8'h22, 64'hA, 2'd0, 1, 7'b0001000, 0, 0);
    fill("R4", 6, 2'd0);
    do_store("R4", 0, 40'hC200, 8'h22, 64'hB, 2'd0, 0, 0, 0, 0);
    do_store("R4", 0, 40'hC300, 8'h22, 64'hC, 2'd0, 0, 0, 0, 0);
    en_ue = 1; en_ce = 1;
    // R5/R6 parity plus two-bit, with hypervisor entries present
    do_store("R6", 0, 40'hD000, 8'h5a, 64'hD, 2'd0, 1, 7'b0000011, 1, 0);
    fill("R5", 6, 2'd2);
    do_store("R5", 0, 40'hD100, 8'h5a, 64'hE, 2'd1, 0, 0, 0, 0);
    do_store("R6", 0, 40'hD200, 8'h5a, 64'hF, 2'd0, 0, 0, 0, 0);
    // R11 second error with status full
    do_store("R11", 0, 40'hD300, 8'h01, 64'h10, 2'd3, 0, 0, 1, 0);
    fill("R11", 7, 2'd0);
    do_store("R11", 0, 40'hD400, 8'h01, 64'h11, 2'd0, 0, 0, 0, 0);
    do_clr("R11");
    // R5 corrupt privilege code in a valid slot
    do_store("R5", 0, 40'hE000, 8'h01, 64'h12, 2'd3, 0, 0, 1, 0);
    fill("R5", 7, 2'd1);
    do_store("R5", 0, 40'hE100, 8'h01, 64'h13, 2'd0, 0, 0, 0, 0);
    do_clr("R5");
    // R10 flush at rate 3, R13 tick with store dropped
    flush_rate = 16'd3;
    do_tick("R10"); do_tick("R10");
    do_store("R13", 0, 40'hF000, 8'h01, 64'h14, 2'd0, 0, 0, 0, 1);
    do_tick("R10");
    do_tick("R13");
    flush_rate = 16'd0;
    do_tick("R10");

    // constrained random phase
    for (int op = 0; op < 600; op++) begin
      int sel = $urandom % 100;
      if (sel < 70) begin
        bit injd = ($urandom % 5) == 0;
        int b1 = $urandom % 7;
        int b2 = (b1 + 1 + $urandom % 6) % 7;
        logic [6:0] msk = 7'(1 << b1);
        logic [1:0] c = 2'($urandom % 3);
        if ($urandom % 2) msk[b2] = 1'b1;
        if (($urandom % 12) == 0) c = 2'd3;
        do_store("R1", ($urandom % 10) == 0, {8'h0, $urandom}, 8'($urandom),
                 {$urandom, $urandom}, c, injd, msk, ($urandom % 10) == 0,
                 ($urandom % 8) == 0);
      end else if (sel < 85) do_tick("R10");
      else if (sel < 93) do_clr("R11");
      else if (sel < 97) begin en_ue = $urandom % 2; en_ce = $urandom % 2; end
      else flush_rate = 16'($urandom % 5);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule